// File: doc/BRIEF.md
# Byte ALU with Status Flag Update

This block is the arithmetic and logic unit of a small 8-bit processor datapath. In each cycle it takes an operation code, two byte operands, a 16-bit register pair with a 6-bit immediate for the word forms, and the current status byte. One clock edge later it presents the result, the new status byte and a write-enable that tells the register file whether to store the result. Operand fetch, the register file and multiplication are handled elsewhere.

Every operation updates only its own set of flags. The status byte keeps a fixed layout: bit 7 interrupt enable (I), bit 6 transfer bit (T), bit 5 half carry (H), bit 4 sign (S), bit 3 overflow (V), bit 2 negative (N), bit 1 zero (Z), bit 0 carry (C). I and T are never touched here. The carry-chained subtract and compare keep Z set only when the previous Z was set, so a multi-byte compare can be built from a chain of byte operations.

Operation codes (op_i): 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 compare, 5 compare with carry, 6 and, 7 or, 8 xor, 9 complement, 10 negate, 11 increment, 12 decrement, 13 logical shift right, 14 arithmetic shift right, 15 rotate right through carry, 16 nibble swap, 17 word add immediate, 18 word subtract immediate; codes 19 to 31 are unused.

Top module: `status_alu`

## Requirements
- R1: Add (0) and add-with-carry (1, carry-in is status bit 0) write a+b(+C) to result bits 7:0; C is the carry out of bit 7, H the carry out of bit 3, V signed overflow, N result bit 7, Z set when the byte result is zero, S = N xor V.
- R2: Subtract (2) and subtract-with-carry (3, borrow-in is status bit 0) write a-b(-C); C is the borrow out of bit 7, H the borrow out of bit 3, V signed overflow, N result bit 7, S = N xor V; plain subtract and compare set Z whenever the result is zero.
- R3: Subtract-with-carry (3) and compare-with-carry (5) set Z only when the result is zero and status bit 1 was already set; otherwise Z is cleared.
- R4: Compare (4) and compare-with-carry (5) update flags exactly as the matching subtract but hold the write-enable low.
- R5: And (6), or (7), xor (8) and complement (9) clear V, copy result bit 7 into N and S, set Z on a zero result and keep H; the first three keep C, complement forces C to 1.
- R6: Negate (10) writes 0-a; C is set for any non-zero result, Z for a zero result, V only for result 0x80, N is result bit 7, S = N xor V, and H is bit 3 of (result or operand).
- R7: Increment (11) and decrement (12) keep C and H; V is set when the result is 0x80 for increment or 0x7F for decrement; N, Z and S = N xor V follow the result.
- R8: Logical shift right (13) fills bit 7 with 0, arithmetic shift right (14) keeps bit 7, rotate (15) brings the old C into bit 7; all three put the old bit 0 into C, set V = N xor C, S = N xor V, Z on a zero result and keep H.
- R9: Word add (17) and word subtract (18) add or subtract the zero-extended 6-bit immediate to the 16-bit pair, write all 16 result bits, set N from result bit 15, Z when all 16 bits are zero, C and V from bit 15 of the old and new values, S = N xor V, and keep H.
- R10: Nibble swap (16) exchanges bits 7:4 and 3:0 of a and leaves the whole status byte unchanged.
- R11: Status bits 7 and 6 pass through unchanged for every operation code.
- R12: While reset is low the result, the status output and the write-enable are all zero.
- R13: Outputs reflect the inputs sampled at the previous rising clock edge (one cycle of latency); for byte operations result bits 15:8 are zero.
- R14: An unused operation code (19 to 31) holds the write-enable low and returns the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First byte operand |
| b_i | input | 8 | Second byte operand or immediate |
| pair_i | input | 16 | Register pair for the word forms |
| imm_i | input | 6 | Immediate for the word forms |
| sreg_i | input | 8 | Current status byte |
| res_o | output | 16 | Result (bits 15:8 used by word forms only) |
| sreg_o | output | 8 | New status byte |
| we_o | output | 1 | Result write-enable |

## Verification
The hardest situations to reach are the narrow flag corners: the carry-chained Z rule needs a zero result paired with a previous Z of both values, and the overflow cases of negate, increment and decrement each fire for a single operand value. Directed vectors place the block on each of these points (0x80 negated, 0x7F incremented, 0x80 decremented, a zero difference with Z both set and clear, word wrap at 0xFFFF and 0x0000) before a long run of random operands and status bytes compares every cycle against an independent integer model through a scoreboard queue.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int IMM_W  = 6;
    localparam int OP_W   = 5;

    // status bit positions (layout fixed by the instruction set)
    localparam int F_C = 0;
    localparam int F_Z = 1;
    localparam int F_N = 2;
    localparam int F_V = 3;
    localparam int F_S = 4;
    localparam int F_H = 5;
    localparam int F_T = 6;
    localparam int F_I = 7;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
        OP_CMP  = 5'd4,  OP_CMPC = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
        OP_XOR  = 5'd8,  OP_COM  = 5'd9,  OP_NEG  = 5'd10, OP_INC  = 5'd11,
        OP_DEC  = 5'd12, OP_LSR  = 5'd13, OP_ASR  = 5'd14, OP_ROR  = 5'd15,
        OP_SWAP = 5'd16, OP_WADD = 5'd17, OP_WSUB = 5'd18
    } alu_op_e;

    typedef struct packed {
        logic              we;
        logic [WORD_W-1:0] res;
        logic [BYTE_W-1:0] sreg;
    } alu_state_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         half,
    output logic         cout,
    output logic         ovf
);
    localparam int HB = 3;   // half-carry taken from bit 3

    logic [W-1:0] cvec;
    logic [W-1:0] ovec;
    logic [W-1:0] cin_ext;

    always_comb begin
        cin_ext = {{(W-1){1'b0}}, cin};
        if (sub) begin
            r    = a - b - cin_ext;
            cvec = (~a & b) | (b & r) | (r & ~a);
            ovec = (a & ~b & ~r) | (~a & b & r);
        end else begin
            r    = a + b + cin_ext;
            cvec = (a & b) | (a & ~r) | (b & ~r);
            ovec = (a & b & ~r) | (~a & ~b & r);
        end
        half = cvec[HB];
        cout = cvec[W-1];
        ovf  = ovec[W-1];
    end
endmodule

// File: rtl/alu_unary.sv
module alu_unary
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic            cin,
    output logic [W-1:0]    r
);
    localparam int HALF = W / 2;

    always_comb begin
        unique case (op)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_COM:  r = ~a;
            OP_NEG:  r = '0 - a;
            OP_INC:  r = a + {{(W-1){1'b0}}, 1'b1};
            OP_DEC:  r = a - {{(W-1){1'b0}}, 1'b1};
            OP_LSR:  r = {1'b0, a[W-1:1]};
            OP_ASR:  r = {a[W-1], a[W-1:1]};
            OP_ROR:  r = {cin, a[W-1:1]};
            OP_SWAP: r = {a[HALF-1:0], a[W-1:HALF]};
            default: r = '0;
        endcase
    end
endmodule

// File: rtl/alu_word.sv
module alu_word #(
    parameter int W  = 16,
    parameter int KW = 6
) (
    input  logic [W-1:0]  pair,
    input  logic [KW-1:0] imm,
    input  logic          sub,
    output logic [W-1:0]  r,
    output logic          cout,
    output logic          ovf
);
    logic [W-1:0] k_ext;

    always_comb begin
        k_ext = {{(W-KW){1'b0}}, imm};
        if (sub) begin
            r    = pair - k_ext;
            cout = r[W-1] & ~pair[W-1];
            ovf  = ~r[W-1] & pair[W-1];
        end else begin
            r    = pair + k_ext;
            cout = ~r[W-1] & pair[W-1];
            ovf  = r[W-1] & ~pair[W-1];
        end
    end
endmodule

// File: rtl/status_alu.sv
module status_alu
    import alu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OP_W-1:0]     op_i,
    input  logic [BYTE_W-1:0]   a_i,
    input  logic [BYTE_W-1:0]   b_i,
    input  logic [WORD_W-1:0]   pair_i,
    input  logic [IMM_W-1:0]    imm_i,
    input  logic [BYTE_W-1:0]   sreg_i,
    output logic [WORD_W-1:0]   res_o,
    output logic [BYTE_W-1:0]   sreg_o,
    output logic                we_o
);
    localparam int PAD = WORD_W - BYTE_W;

    alu_state_t st_d, st_q;

    logic              is_sub, chained, carry_in;
    logic [BYTE_W-1:0] as_r, un_r;
    logic              as_h, as_c, as_v;
    logic [WORD_W-1:0] w_r;
    logic              w_c, w_v;

    always_comb begin
        is_sub   = (op_i == OP_SUB) || (op_i == OP_SBC) ||
                   (op_i == OP_CMP) || (op_i == OP_CMPC);
        chained  = (op_i == OP_SBC) || (op_i == OP_CMPC);
        carry_in = ((op_i == OP_ADC) || chained) ? sreg_i[F_C] : 1'b0;
    end

    alu_addsub #(.W(BYTE_W)) u_addsub (
        .a(a_i), .b(b_i), .cin(carry_in), .sub(is_sub),
        .r(as_r), .half(as_h), .cout(as_c), .ovf(as_v)
    );

    alu_unary #(.W(BYTE_W)) u_unary (
        .op(op_i), .a(a_i), .b(b_i), .cin(sreg_i[F_C]), .r(un_r)
    );

    alu_word #(.W(WORD_W), .KW(IMM_W)) u_word (
        .pair(pair_i), .imm(imm_i), .sub(op_i == OP_WSUB),
        .r(w_r), .cout(w_c), .ovf(w_v)
    );

    always_comb begin
        st_d.we   = 1'b0;
        st_d.res  = '0;
        st_d.sreg = sreg_i;
        unique case (op_i)
            OP_ADD, OP_ADC: begin
                st_d.we        = 1'b1;
                st_d.res       = {{PAD{1'b0}}, as_r};
                st_d.sreg[F_H] = as_h;
                st_d.sreg[F_C] = as_c;
                st_d.sreg[F_V] = as_v;
                st_d.sreg[F_N] = as_r[BYTE_W-1];
                st_d.sreg[F_S] = as_r[BYTE_W-1] ^ as_v;
                st_d.sreg[F_Z] = (as_r == '0);
            end
            OP_SUB, OP_SBC, OP_CMP, OP_CMPC: begin
                st_d.we        = (op_i == OP_SUB) || (op_i == OP_SBC);
                st_d.res       = st_d.we ? {{PAD{1'b0}}, as_r} : '0;
                st_d.sreg[F_H] = as_h;
                st_d.sreg[F_C] = as_c;
                st_d.sreg[F_V] = as_v;
                st_d.sreg[F_N] = as_r[BYTE_W-1];
                st_d.sreg[F_S] = as_r[BYTE_W-1] ^ as_v;
                st_d.sreg[F_Z] = (as_r == '0) & (chained ? sreg_i[F_Z] : 1'b1);
            end
            OP_AND, OP_OR, OP_XOR, OP_COM: begin
                st_d.we        = 1'b1;
                st_d.res       = {{PAD{1'b0}}, un_r};
                st_d.sreg[F_V] = 1'b0;
                st_d.sreg[F_N] = un_r[BYTE_W-1];
                st_d.sreg[F_S] = un_r[BYTE_W-1];
                st_d.sreg[F_Z] = (un_r == '0);
                if (op_i == OP_COM) st_d.sreg[F_C] = 1'b1;
            end
            OP_NEG: begin
                st_d.we        = 1'b1;
                st_d.res       = {{PAD{1'b0}}, un_r};
                st_d.sreg[F_H] = un_r[3] | a_i[3];
                st_d.sreg[F_C] = (un_r != '0);
                st_d.sreg[F_Z] = (un_r == '0);
                st_d.sreg[F_V] = (un_r == 8'h80);
                st_d.sreg[F_N] = un_r[BYTE_W-1];
                st_d.sreg[F_S] = un_r[BYTE_W-1] ^ (un_r == 8'h80);
            end
            OP_INC, OP_DEC: begin
                st_d.we        = 1'b1;
                st_d.res       = {{PAD{1'b0}}, un_r};
                st_d.sreg[F_V] = (op_i == OP_INC) ? (un_r == 8'h80) : (un_r == 8'h7F);
                st_d.sreg[F_N] = un_r[BYTE_W-1];
                st_d.sreg[F_S] = un_r[BYTE_W-1] ^ st_d.sreg[F_V];
                st_d.sreg[F_Z] = (un_r == '0);
            end
            OP_LSR, OP_ASR, OP_ROR: begin
                st_d.we        = 1'b1;
                st_d.res       = {{PAD{1'b0}}, un_r};
                st_d.sreg[F_C] = a_i[0];
                st_d.sreg[F_N] = un_r[BYTE_W-1];
                st_d.sreg[F_V] = un_r[BYTE_W-1] ^ a_i[0];
                st_d.sreg[F_S] = a_i[0];
                st_d.sreg[F_Z] = (un_r == '0);
            end
            OP_SWAP: begin
                st_d.we  = 1'b1;
                st_d.res = {{PAD{1'b0}}, un_r};
            end
            OP_WADD, OP_WSUB: begin
                st_d.we        = 1'b1;
                st_d.res       = w_r;
                st_d.sreg[F_C] = w_c;
                st_d.sreg[F_V] = w_v;
                st_d.sreg[F_N] = w_r[WORD_W-1];
                st_d.sreg[F_S] = w_r[WORD_W-1] ^ w_v;
                st_d.sreg[F_Z] = (w_r == '0);
            end
            default: ;
        endcase
        st_d.sreg[F_I] = sreg_i[F_I];
        st_d.sreg[F_T] = sreg_i[F_T];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o  = st_q.res;
    assign sreg_o = st_q.sreg;
    assign we_o   = st_q.we;

    // interrupt and transfer bits survive every operation
    assert_it_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> sreg_o[F_I:F_T] == $past(sreg_i[F_I:F_T]));

    // compares never request a register write
    assert_cmp_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP || op_i == OP_CMPC) |=> !we_o);

    // chained forms cannot raise Z when it was clear before
    assert_chain_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == OP_SBC || op_i == OP_CMPC) && !sreg_i[F_Z]) |=> !sreg_o[F_Z]);

    // increment and decrement keep carry and half carry
    assert_incdec_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_INC || op_i == OP_DEC) |=>
        (sreg_o[F_C] == $past(sreg_i[F_C]) && sreg_o[F_H] == $past(sreg_i[F_H])));

    // swap leaves the status byte alone
    assert_swap_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SWAP) |=> sreg_o == $past(sreg_i));

    // unused codes never write
    assert_unused_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > OP_WSUB) |=> (!we_o && sreg_o == $past(sreg_i)));

endmodule

// File: tb/status_alu_bench.sv
module status_alu_bench;
    import alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  op_i = '0;
    logic [7:0]  a_i = '0, b_i = '0, sreg_i = '0;
    logic [15:0] pair_i = '0;
    logic [5:0]  imm_i = '0;
    logic [15:0] res_o;
    logic [7:0]  sreg_o;
    logic        we_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    status_alu u_status_alu (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .pair_i(pair_i), .imm_i(imm_i), .sreg_i(sreg_i),
        .res_o(res_o), .sreg_o(sreg_o), .we_o(we_o)
    );

    typedef struct {
        logic [4:0]  op;
        logic        we;
        logic [15:0] res;
        logic [7:0]  sr;
    } item_t;

    item_t sb_q[$];

    function automatic string req_of(input logic [4:0] op);
        case (op)
            0, 1:        return "R1";
            2:           return "R2";
            3:           return "R3";
            4, 5:        return "R4";
            6, 7, 8, 9:  return "R5";
            10:          return "R6";
            11, 12:      return "R7";
            13, 14, 15:  return "R8";
            16:          return "R10";
            17, 18:      return "R9";
            default:     return "R14";
        endcase
    endfunction

    // independent integer model of the requirements
    function automatic item_t model(input logic [4:0] op, input logic [7:0] a,
                                    input logic [7:0] b, input logic [15:0] p,
                                    input logic [5:0] k, input logic [7:0] s);
        item_t it;
        int ai, bi, ci, t;
        logic [7:0] r;
        logic [15:0] w;
        ai = int'(a); bi = int'(b); ci = int'(s[0]);
        it.op = op; it.we = 1'b0; it.res = '0; it.sr = s;
        case (op)
            0, 1: begin
                if (op == 0) ci = 0;
                t = ai + bi + ci; r = t[7:0];
                it.we = 1; it.res = {8'h00, r};
                it.sr[0] = t > 255;
                it.sr[5] = ((ai % 16) + (bi % 16) + ci) > 15;
                it.sr[3] = (a[7] == b[7]) && (r[7] != a[7]);
                it.sr[2] = r[7]; it.sr[1] = (r == 0);
                it.sr[4] = it.sr[2] ^ it.sr[3];
            end
            2, 3, 4, 5: begin
                if (op == 2 || op == 4) ci = 0;
                t = ai - bi - ci; r = t[7:0];
                it.we = (op == 2 || op == 3);
                it.res = it.we ? {8'h00, r} : 16'h0;
                it.sr[0] = ai < bi + ci;
                it.sr[5] = (ai % 16) < (bi % 16) + ci;
                it.sr[3] = (a[7] != b[7]) && (r[7] != a[7]);
                it.sr[2] = r[7];
                it.sr[1] = (op == 3 || op == 5) ? ((r == 0) && s[1]) : (r == 0);
                it.sr[4] = it.sr[2] ^ it.sr[3];
            end
            6, 7, 8, 9: begin
                r = (op == 6) ? (a & b) : (op == 7) ? (a | b) : (op == 8) ? (a ^ b) : ~a;
                it.we = 1; it.res = {8'h00, r};
                it.sr[3] = 0; it.sr[2] = r[7]; it.sr[4] = r[7]; it.sr[1] = (r == 0);
                if (op == 9) it.sr[0] = 1;
            end
            10: begin
                t = (256 - ai) % 256; r = t[7:0];
                it.we = 1; it.res = {8'h00, r};
                it.sr[0] = (r != 0); it.sr[1] = (r == 0);
                it.sr[3] = (r == 8'h80); it.sr[2] = r[7];
                it.sr[4] = it.sr[2] ^ it.sr[3];
                it.sr[5] = r[3] | a[3];
            end
            11, 12: begin
                t = (op == 11) ? (ai + 1) % 256 : (ai + 255) % 256; r = t[7:0];
                it.we = 1; it.res = {8'h00, r};
                it.sr[3] = (op == 11) ? (r == 8'h80) : (r == 8'h7F);
                it.sr[2] = r[7]; it.sr[1] = (r == 0);
                it.sr[4] = it.sr[2] ^ it.sr[3];
            end
            13, 14, 15: begin
                t = ai / 2;
                if (op == 14 && a[7]) t = t + 128;
                if (op == 15 && s[0]) t = t + 128;
                r = t[7:0];
                it.we = 1; it.res = {8'h00, r};
                it.sr[0] = a[0]; it.sr[2] = r[7];
                it.sr[3] = r[7] ^ a[0]; it.sr[4] = it.sr[2] ^ it.sr[3];
                it.sr[1] = (r == 0);
            end
            16: begin
                it.we = 1; it.res = {8'h00, a[3:0], a[7:4]};
            end
            17, 18: begin
                if (op == 17) begin
                    t = int'(p) + int'(k); w = t[15:0];
                    it.sr[0] = t > 65535;
                    it.sr[3] = !p[15] && w[15];
                end else begin
                    t = int'(p) - int'(k); w = t[15:0];
                    it.sr[0] = int'(k) > int'(p);
                    it.sr[3] = p[15] && !w[15];
                end
                it.we = 1; it.res = w;
                it.sr[2] = w[15]; it.sr[1] = (w == 0);
                it.sr[4] = it.sr[2] ^ it.sr[3];
            end
            default: ;
        endcase
        return it;
    endfunction

    task automatic drive(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [15:0] p, input logic [5:0] k, input logic [7:0] s);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; pair_i = p; imm_i = k; sreg_i = s;
        sb_q.push_back(model(op, a, b, p, k, s));
    endtask

    // monitor: each item is due one edge after it was driven (R13)
    always @(posedge clk) begin
        item_t e;
        #1;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_tests++;
            if (we_o !== e.we || res_o !== e.res || sreg_o !== e.sr) begin
                n_fail++;
                $display("FAIL %s R13 op=%0d actual we=%b res=%h sreg=%b expected we=%b res=%h sreg=%b",
                         req_of(e.op), e.op, we_o, res_o, sreg_o, e.we, e.res, e.sr);
            end
            n_tests++;
            if (sreg_o[7:6] !== e.sr[7:6]) begin
                n_fail++;
                $display("FAIL R11 op=%0d actual IT=%b expected IT=%b", e.op, sreg_o[7:6], e.sr[7:6]);
            end
        end
    end

    initial begin : watchdog
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        op_i = 5'd0; a_i = 8'h55; b_i = 8'hAA; sreg_i = 8'hFF;
        repeat (3) @(posedge clk);
        #1;
        n_tests++;
        if (res_o !== 16'h0 || sreg_o !== 8'h00 || we_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R12 actual res=%h sreg=%h we=%b expected 0 0 0", res_o, sreg_o, we_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1 corners
        drive(0, 8'h0F, 8'h01, 0, 0, 8'h00);
        drive(0, 8'hFF, 8'h01, 0, 0, 8'hC0);
        drive(0, 8'h7F, 8'h01, 0, 0, 8'h00);
        drive(1, 8'h10, 8'h20, 0, 0, 8'h01);
        // R2 / R3 / R4 corners
        drive(2, 8'h00, 8'h01, 0, 0, 8'h00);
        drive(2, 8'h80, 8'h01, 0, 0, 8'h00);
        drive(3, 8'h05, 8'h04, 0, 0, 8'h03);
        drive(3, 8'h05, 8'h04, 0, 0, 8'h01);
        drive(5, 8'h12, 8'h12, 0, 0, 8'h00);
        drive(5, 8'h12, 8'h12, 0, 0, 8'h02);
        drive(4, 8'h33, 8'h33, 0, 0, 8'h40);
        // R5
        drive(6, 8'hF0, 8'h0F, 0, 0, 8'h29);
        drive(7, 8'h80, 8'h01, 0, 0, 8'h08);
        drive(8, 8'hAA, 8'hAA, 0, 0, 8'h21);
        drive(9, 8'h00, 8'h00, 0, 0, 8'h00);
        // R6
        drive(10, 8'h00, 0, 0, 0, 8'hFF);
        drive(10, 8'h80, 0, 0, 0, 8'h00);
        drive(10, 8'h01, 0, 0, 0, 8'h00);
        // R7
        drive(11, 8'h7F, 0, 0, 0, 8'h21);
        drive(11, 8'hFF, 0, 0, 0, 8'h00);
        drive(12, 8'h80, 0, 0, 0, 8'h01);
        drive(12, 8'h01, 0, 0, 0, 8'h20);
        // R8
        drive(13, 8'h01, 0, 0, 0, 8'h20);
        drive(14, 8'h81, 0, 0, 0, 8'h00);
        drive(15, 8'h02, 0, 0, 0, 8'h01);
        // R10
        drive(16, 8'h3C, 0, 0, 0, 8'hA5);
        // R9
        drive(17, 0, 0, 16'hFFFF, 6'd1, 8'h00);
        drive(17, 0, 0, 16'h7FFF, 6'd1, 8'h20);
        drive(18, 0, 0, 16'h0000, 6'd1, 8'h00);
        drive(18, 0, 0, 16'h8000, 6'd1, 8'h00);
        drive(18, 0, 0, 16'h0020, 6'd32, 8'h00);
        // R14
        drive(25, 8'h11, 8'h22, 16'h1234, 6'd3, 8'h5A);
        drive(31, 8'hFF, 8'hFF, 16'hFFFF, 6'd63, 8'hC3);

        // random sweep over all codes
        for (int i = 0; i < 2000; i++) begin
            drive(5'($urandom_range(0, 31)), 8'($urandom), 8'($urandom),
                  16'($urandom), 6'($urandom), 8'($urandom));
        end

        repeat (4) @(posedge clk);
        #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule